// File: doc/BRIEF.md
# Secured Configuration Readback Controller

The controller guards a small on-chip configuration store made of three parts: an array of pattern words, one user signature word and a sticky lock bit. A host issues commands over a request/acknowledge interface. It can program a pattern word, read a pattern word, program or read the signature, set the lock, or erase the whole pattern array. The controller takes a command only while it is not busy. Every command it takes returns exactly one acknowledge pulse, and the read data and error flag are valid during that pulse.

Once the lock is set, pattern contents cannot be read back: a pattern read still completes, but it returns a word of all ones. Pattern writes are refused and flagged as errors. The signature stays readable and writable while locked, so the host can always identify the stored design or its revision. Only a full erase clears the lock. The erase walks the array one word per cycle and sets every pattern bit to one, holding busy for the whole walk. Reset loads the blank state: pattern all ones, signature zero, unlocked.

Top module: `cfg_guard_ctrl`

## Requirements
- R1: After reset, busy, ack and locked are 0. Every pattern word reads as all ones and the signature reads as zero.
- R2: Command code 1 writes req_wdata into the pattern word at req_addr when the store is unlocked. A later read with code 2 at that address returns the written value with err=0.
- R3: Every command accepted in the idle state, other than erase, raises ack for exactly one cycle, beginning the cycle after acceptance. Back-to-back commands on consecutive cycles are each acknowledged.
- R4: Command code 5 sets the lock. locked reads 1 from the cycle after acceptance and stays 1 until an erase completes.
- R5: While locked, a pattern read (code 2) is acknowledged with rdata all ones and err=0, whatever the stored word holds.
- R6: While locked, a pattern write (code 1) is acknowledged with err=1 and leaves the pattern word unchanged.
- R7: Code 3 writes the signature and code 4 reads it. Both work whether or not the store is locked, and erase leaves the signature unchanged.
- R8: Command code 6 (erase) raises busy for exactly DEPTH cycles, starting the cycle after acceptance. ack is raised in the cycle that busy falls. After the erase, every pattern word reads all ones and locked is 0.
- R9: A request presented while busy is 1 is ignored: it gets no ack and it does not change the pattern.
- R10: Command codes 0 and 7 are acknowledged with err=1 and change no stored state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Command request, taken when busy is 0 |
| req_cmd | input | 3 | Command code |
| req_addr | input | AW | Pattern word address |
| req_wdata | input | DW | Write data for pattern or signature |
| busy | output | 1 | Erase in progress; requests are ignored |
| ack | output | 1 | One-cycle completion pulse per accepted command |
| rdata | output | DW | Read result, valid with ack |
| err | output | 1 | Command refused or unknown, valid with ack |
| locked | output | 1 | Current lock bit |

## Verification
Every command other than erase acknowledges in the cycle after the edge that takes it. The driver pushes an expected rdata/err item when it issues the command, and the monitor pops and compares that item at the first falling edge after the acknowledging edge. For an erase, the bench counts the falling edges at which busy is high and expects exactly DEPTH of them. The acknowledge for that erase is due at the first falling edge where busy is low again, and the bench keeps issuing requests all through the busy window. Any acknowledge that arrives with no queued item is counted as a failure, and so is any item still queued at the end.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;

  typedef enum logic [2:0] {
    CMD_BAD0     = 3'd0,
    CMD_PAT_WR   = 3'd1,
    CMD_PAT_RD   = 3'd2,
    CMD_SIG_WR   = 3'd3,
    CMD_SIG_RD   = 3'd4,
    CMD_LOCK     = 3'd5,
    CMD_ERASE    = 3'd6,
    CMD_BAD7     = 3'd7
  } cmd_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_ERASE = 1'b1
  } seq_state_e;

endpackage

// File: rtl/cfg_guard_store.sv
module cfg_guard_store #(
  parameter int DW    = 8,
  parameter int AW    = 4,
  parameter int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pat_we,
  input  logic [AW-1:0] pat_waddr,
  input  logic [DW-1:0] pat_wdata,
  input  logic [AW-1:0] pat_raddr,
  output logic [DW-1:0] pat_rdata,
  input  logic          wipe_we,
  input  logic [AW-1:0] wipe_row,
  input  logic          sig_we,
  input  logic [DW-1:0] sig_wdata,
  output logic [DW-1:0] sig_q,
  input  logic          lock_set,
  input  logic          lock_clr,
  output logic          lock_q
);

  logic [DW-1:0] row_q [DEPTH];
  logic          lock_d;
  logic [DW-1:0] sig_d;

  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    localparam logic [AW-1:0] ROW_ID = AW'(g);
    logic          row_en;
    logic [DW-1:0] row_d;

    always_comb begin
      row_en = 1'b0;
      row_d  = row_q[g];
      if (wipe_we && (wipe_row == ROW_ID)) begin
        row_en = 1'b1;
        row_d  = '1;
      end else if (pat_we && (pat_waddr == ROW_ID)) begin
        row_en = 1'b1;
        row_d  = pat_wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        row_q[g] <= '1;
      end else if (row_en) begin
        row_q[g] <= row_d;
      end
    end
  end

  assign pat_rdata = row_q[pat_raddr];

  always_comb begin
    sig_d = sig_q;
    if (sig_we) sig_d = sig_wdata;
  end

  always_comb begin
    lock_d = lock_q;
    if (lock_clr)      lock_d = 1'b0;
    else if (lock_set) lock_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      sig_q  <= sig_d;
      lock_q <= lock_d;
    end
  end

  // R6: pattern words are never written while the lock is set
  a_r6_no_write_locked: assert property (@(posedge clk) disable iff (!rst_n)
    pat_we |-> !lock_q);

  // R4: the lock only drops through the erase path
  a_r4_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !lock_clr) |=> lock_q);

  // R8: erase completion leaves the store unlocked
  a_r8_erase_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    lock_clr |=> !lock_q);

endmodule

// File: rtl/cfg_guard_seq.sv
module cfg_guard_seq
  import cfg_guard_pkg::*;
#(
  parameter int DW    = 8,
  parameter int AW    = 4,
  parameter int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_cmd,
  input  logic [DW-1:0] pat_rdata,
  input  logic [DW-1:0] sig_q,
  input  logic          lock_q,
  output logic          pat_we,
  output logic          wipe_we,
  output logic [AW-1:0] wipe_row,
  output logic          sig_we,
  output logic          lock_set,
  output logic          lock_clr,
  output logic          busy,
  output logic          ack,
  output logic [DW-1:0] rdata,
  output logic          err
);

  localparam logic [AW-1:0] LAST_ROW = AW'(DEPTH - 1);

  seq_state_e    state_q, state_d;
  logic [AW-1:0] cnt_q, cnt_d;
  logic          ack_q, ack_d;
  logic          err_q, err_d;
  logic [DW-1:0] rdata_q, rdata_d;
  logic          take;
  cmd_e          cmd;

  assign cmd  = cmd_e'(req_cmd);
  assign take = req_valid && (state_q == ST_IDLE);

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    ack_d    = 1'b0;
    err_d    = 1'b0;
    rdata_d  = rdata_q;
    pat_we   = 1'b0;
    wipe_we  = 1'b0;
    sig_we   = 1'b0;
    lock_set = 1'b0;
    lock_clr = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          case (cmd)
            CMD_PAT_WR: begin
              ack_d = 1'b1;
              if (lock_q) err_d  = 1'b1;
              else        pat_we = 1'b1;
            end
            CMD_PAT_RD: begin
              ack_d   = 1'b1;
              rdata_d = lock_q ? '1 : pat_rdata;
            end
            CMD_SIG_WR: begin
              ack_d  = 1'b1;
              sig_we = 1'b1;
            end
            CMD_SIG_RD: begin
              ack_d   = 1'b1;
              rdata_d = sig_q;
            end
            CMD_LOCK: begin
              ack_d    = 1'b1;
              lock_set = 1'b1;
            end
            CMD_ERASE: begin
              state_d = ST_ERASE;
              cnt_d   = '0;
            end
            default: begin
              ack_d = 1'b1;
              err_d = 1'b1;
            end
          endcase
        end
      end
      ST_ERASE: begin
        wipe_we = 1'b1;
        if (cnt_q == LAST_ROW) begin
          state_d  = ST_IDLE;
          ack_d    = 1'b1;
          lock_clr = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ack_q   <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ack_q   <= ack_d;
      err_q   <= err_d;
      rdata_q <= rdata_d;
    end
  end

  assign wipe_row = cnt_q;
  assign busy     = (state_q == ST_ERASE);
  assign ack      = ack_q;
  assign err      = err_q;
  assign rdata    = rdata_q;

  // R3: a taken non-erase command acknowledges on the next cycle
  a_r3_ack_next: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (cmd != CMD_ERASE)) |=> ack);

  // R8: a taken erase makes the block busy on the next cycle
  a_r8_erase_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (cmd == CMD_ERASE)) |=> busy);

  // R9: no acknowledge while the erase walk runs
  a_r9_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ack);

  // R5: locked pattern reads return a blanked word
  a_r5_blank_read: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (cmd == CMD_PAT_RD) && lock_q) |=> (rdata == '1));

endmodule

// File: rtl/cfg_guard_ctrl.sv
module cfg_guard_ctrl
  import cfg_guard_pkg::*;
#(
  parameter int DW    = 8,
  parameter int AW    = 4,
  parameter int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_cmd,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          ack,
  output logic [DW-1:0] rdata,
  output logic          err,
  output logic          locked
);

  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic          pat_we, wipe_we, sig_we, lock_set, lock_clr, lock_q;
  logic [AW-1:0] wipe_row;
  logic [DW-1:0] pat_rdata, sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  cfg_guard_seq #(.DW(DW), .AW(AW), .DEPTH(DEPTH)) seq_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_valid (req_valid),
    .req_cmd   (req_cmd),
    .pat_rdata (pat_rdata),
    .sig_q     (sig_q),
    .lock_q    (lock_q),
    .pat_we    (pat_we),
    .wipe_we   (wipe_we),
    .wipe_row  (wipe_row),
    .sig_we    (sig_we),
    .lock_set  (lock_set),
    .lock_clr  (lock_clr),
    .busy      (busy),
    .ack       (ack),
    .rdata     (rdata),
    .err       (err)
  );

  cfg_guard_store #(.DW(DW), .AW(AW), .DEPTH(DEPTH)) store_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .pat_we    (pat_we),
    .pat_waddr (req_addr),
    .pat_wdata (req_wdata),
    .pat_raddr (req_addr),
    .pat_rdata (pat_rdata),
    .wipe_we   (wipe_we),
    .wipe_row  (wipe_row),
    .sig_we    (sig_we),
    .sig_wdata (req_wdata),
    .sig_q     (sig_q),
    .lock_set  (lock_set),
    .lock_clr  (lock_clr),
    .lock_q    (lock_q)
  );

  assign locked = lock_q;

endmodule

// File: tb/cfg_guard_ctrl_tb_top.sv
module cfg_guard_ctrl_tb_top;

  localparam int DW    = 8;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;

  typedef struct {
    logic [DW-1:0] data;
    logic          err;
    bit            chk_data;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic [2:0]    req_cmd;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          busy, ack, err, locked;
  logic [DW-1:0] rdata;

  int   total = 0;
  int   bad   = 0;
  bit   done  = 0;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  cfg_guard_ctrl #(.DW(DW), .AW(AW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .ack(ack),
    .rdata(rdata), .err(err), .locked(locked)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] c, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input logic [DW-1:0] xd,
                       input logic xe, input bit cd, input string tag);
    exp_t e;
    while (busy) @(negedge clk);
    e.data = xd; e.err = xe; e.chk_data = cd; e.tag = tag;
    sb_q.push_back(e);
    req_valid = 1'b1; req_cmd = c; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: compares every acknowledge against the oldest expectation
  always @(negedge clk) begin
    if (rst_n && ack) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R9", "unexpected ack", 32'(ack), 32'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(err == e.err, e.tag, "err", 32'(err), 32'(e.err));
        if (e.chk_data)
          chk(rdata == e.data, e.tag, "rdata", 32'(rdata), 32'(e.data));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; req_valid = 1'b0; req_cmd = '0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(busy == 1'b0, "R1", "busy", 32'(busy), 0);
    chk(ack == 1'b0, "R1", "ack", 32'(ack), 0);
    chk(locked == 1'b0, "R1", "locked", 32'(locked), 0);
    issue(3'd2, 4'd3, 8'h00, 8'hFF, 1'b0, 1, "R1");
    issue(3'd4, 4'd0, 8'h00, 8'h00, 1'b0, 1, "R1");

    // R2 program and read back
    issue(3'd1, 4'd3, 8'h5A, 8'h00, 1'b0, 0, "R2");
    issue(3'd1, 4'd15, 8'hC3, 8'h00, 1'b0, 0, "R2");
    issue(3'd1, 4'd0, 8'h01, 8'h00, 1'b0, 0, "R2");
    issue(3'd2, 4'd3, 8'h00, 8'h5A, 1'b0, 1, "R2");
    issue(3'd2, 4'd15, 8'h00, 8'hC3, 1'b0, 1, "R2");
    issue(3'd2, 4'd0, 8'h00, 8'h01, 1'b0, 1, "R2");

    // R3 back-to-back on consecutive cycles
    issue(3'd1, 4'd7, 8'h77, 8'h00, 1'b0, 0, "R3");
    issue(3'd2, 4'd7, 8'h00, 8'h77, 1'b0, 1, "R3");

    // R7 signature
    issue(3'd3, 4'd0, 8'hA7, 8'h00, 1'b0, 0, "R7");
    issue(3'd4, 4'd0, 8'h00, 8'hA7, 1'b0, 1, "R7");

    // R10 unknown codes
    issue(3'd0, 4'd3, 8'h00, 8'h00, 1'b1, 0, "R10");
    issue(3'd7, 4'd3, 8'h00, 8'h00, 1'b1, 0, "R10");
    issue(3'd2, 4'd3, 8'h00, 8'h5A, 1'b0, 1, "R10");
    chk(locked == 1'b0, "R10", "locked", 32'(locked), 0);

    // R4 lock
    issue(3'd5, 4'd0, 8'h00, 8'h00, 1'b0, 0, "R4");
    chk(locked == 1'b1, "R4", "locked", 32'(locked), 1);

    // R5 blanked reads, R6 refused writes
    issue(3'd2, 4'd3, 8'h00, 8'hFF, 1'b0, 1, "R5");
    issue(3'd2, 4'd0, 8'h00, 8'hFF, 1'b0, 1, "R5");
    issue(3'd1, 4'd3, 8'h00, 8'h00, 1'b1, 0, "R6");
    issue(3'd2, 4'd3, 8'h00, 8'hFF, 1'b0, 1, "R6");
    issue(3'd5, 4'd0, 8'h00, 8'h00, 1'b0, 0, "R4");
    chk(locked == 1'b1, "R4", "locked after relock", 32'(locked), 1);

    // R7 signature while locked
    issue(3'd4, 4'd0, 8'h00, 8'hA7, 1'b0, 1, "R7");
    issue(3'd3, 4'd0, 8'h3C, 8'h00, 1'b0, 0, "R7");
    issue(3'd4, 4'd0, 8'h00, 8'h3C, 1'b0, 1, "R7");

    // R8 erase with R9 requests during busy
    issue(3'd6, 4'd0, 8'h00, 8'h00, 1'b0, 0, "R8");
    n = 0;
    while (busy && n < 100) begin
      n++;
      req_valid = 1'b1; req_cmd = 3'd1; req_addr = 4'd5; req_wdata = 8'h11;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(n == DEPTH, "R8", "busy cycles", 32'(n), 32'(DEPTH));
    chk(ack == 1'b1, "R8", "ack as busy falls", 32'(ack), 1);
    chk(locked == 1'b0, "R8", "locked after erase", 32'(locked), 0);
    issue(3'd2, 4'd3, 8'h00, 8'hFF, 1'b0, 1, "R8");
    issue(3'd2, 4'd15, 8'h00, 8'hFF, 1'b0, 1, "R8");
    issue(3'd2, 4'd5, 8'h00, 8'hFF, 1'b0, 1, "R9");
    issue(3'd4, 4'd0, 8'h00, 8'h3C, 1'b0, 1, "R7");

    // R2 writes work again after unlock
    issue(3'd1, 4'd9, 8'h96, 8'h00, 1'b0, 0, "R2");
    issue(3'd2, 4'd9, 8'h00, 8'h96, 1'b0, 1, "R2");

    repeat (4) @(negedge clk);
    chk(sb_q.size() == 0, "R3", "pending acks", 32'(sb_q.size()), 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule